// File: doc/BRIEF.md
# Three-Bus Single-Step-Add Processor Datapath

This block is a small accumulator-free processor core whose datapath uses three internal buses. Two source buses carry values out of the register file (or out of the program counter, the instruction register's address field, a constant, or incoming memory data) to the two inputs of the adder unit. The adder output drives the destination bus directly, and any of the four general registers, the program counter, the memory address register, the memory data register or the instruction register can be written from it in the same cycle. With no operand or result buffer registers, a register-to-register add needs a single execute step.

A step sequencer runs instruction fetch, the register add, the memory add, a stop instruction and interrupt entry, each in the smallest number of clock cycles this organization allows. The core talks to a simple synchronous memory through one address and one write-data bus, a read strobe and a write strobe. It receives an interrupt through a request/acknowledge pair. A combinational debug port reads any general register. After every instruction and every interrupt entry the core reports how many cycles that unit of work took, so that cycle counts can be checked from outside.

Instruction encoding (16 bits, opcode in bits 15:12): `0x1` is the register add Rd = Ra + Rb, with Rd in bits 11:10, Ra in bits 9:8 and Rb in bits 7:6. `0x2` is the memory add R0 = R0 + M[X], with X in bits 11:0. `0xF` stops the core. Every other opcode does nothing.

Top module: `dp3_core`

## Requirements
- R1: After reset, all four registers read 0, `halted`, `step_done`, `mem_rd`, `mem_wr` and `irq_ack` are 0, and the first fetch reads address 0.
- R2: Fetch takes three cycles: the address register loads from the program counter, then `mem_rd` strobes at that address while the program counter increments, then the returned word enters the instruction register. Instructions are fetched from consecutive addresses.
- R3: A register add (opcode 0x1) completes in one execute step, so `step_count` reports 4 for it.
- R4: A register add whose destination is also a source uses the old source values. The register file write is synchronous and a same-cycle read returns the previous contents.
- R5: A memory add (opcode 0x2) strobes `mem_rd` at address X, adds the returned word to R0 and writes the sum to R0. It takes three execute steps, so `step_count` reports 6.
- R6: Memory read data is taken exactly one cycle after the cycle in which `mem_rd` is high. It is never taken in any other cycle.
- R7: An interrupt request is acted on only when an instruction completes. Entry takes three cycles. In the last of them `mem_wr` writes the address of the next instruction to 0xFFF while `irq_ack` pulses. The next fetch then comes from 0x100, and `step_count` reports 3.
- R8: The stop instruction (opcode 0xF) reports `step_count` 4 and sets `halted`. From then on `halted` stays high, no memory strobe occurs, and a held interrupt request is not acknowledged.
- R9: Any opcode other than 0x1, 0x2 or 0xF changes no register and reports `step_count` 4.
- R10: `dbg_data` shows, combinationally, the register selected by `dbg_sel`.
- R11: `mem_rd` and `mem_wr` are never high in the same cycle.
- R12: All additions are 16-bit and wrap modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_addr | output | 12 | Memory word address, taken from the address register |
| mem_rd | output | 1 | Read strobe; data is expected in the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 16 | Write data, taken from the data register |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| irq_req | input | 1 | Interrupt request, held until acknowledged |
| irq_ack | output | 1 | One-cycle acknowledge at interrupt entry |
| dbg_sel | input | 2 | Debug register select |
| dbg_data | output | 16 | Contents of the selected register |
| halted | output | 1 | High once the stop instruction has executed |
| step_done | output | 1 | One-cycle pulse after each instruction or interrupt entry |
| step_count | output | 4 | Cycles taken by the unit of work just finished |

## Verification
The assertions assume that memory behaves as the port describes: a word is returned only in the cycle after a read strobe, and a write lands at the current address. They also assume that an interrupt request, once raised, is held until `irq_ack` and then dropped. The bench memory model returns a poison word in every cycle that does not follow a strobe, so data taken in the wrong cycle shows up in the results. The interrupt driver raises the request at a negative edge in the middle of an instruction and clears it at the acknowledge. After the core halts, the driver raises the request again and holds it.

// File: rtl/dp3_pkg.sv
package dp3_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;
  localparam int REG_N  = 4;
  localparam int REG_AW = $clog2(REG_N);
  localparam int STEP_W = 4;
  localparam int OP_W   = 4;

  localparam logic [OP_W-1:0] OPC_RADD = 4'h1;
  localparam logic [OP_W-1:0] OPC_MADD = 4'h2;
  localparam logic [OP_W-1:0] OPC_STOP = 4'hF;

  typedef enum logic [1:0] {A_REG, A_PC, A_IRX, A_CONST} asel_e;
  typedef enum logic       {B_REG, B_MEM} bsel_e;
  typedef enum logic [1:0] {ALU_ADD, ALU_PASSA, ALU_PASSB, ALU_INCA} aluop_e;

  typedef struct packed {
    asel_e             a_sel;
    logic [ADDR_W-1:0] konst;
    bsel_e             b_sel;
    aluop_e            op;
    logic              rf_we;
    logic [REG_AW-1:0] rf_wa;
    logic [REG_AW-1:0] rf_ra;
    logic [REG_AW-1:0] rf_rb;
    logic              pc_ld;
    logic              mar_ld;
    logic              mdr_bus_ld;
    logic              mdr_mem_ld;
    logic              ir_ld;
    logic              mem_rd;
    logic              mem_wr;
    logic              irq_ack;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] add_wrap(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    logic [DATA_W:0] full;
    full = {1'b0, a} + {1'b0, b};
    return full[DATA_W-1:0];
  endfunction

  function automatic logic [OP_W-1:0] fld_op(input logic [DATA_W-1:0] ir);
    return ir[DATA_W-1 -: OP_W];
  endfunction

  function automatic logic [REG_AW-1:0] fld_rd(input logic [DATA_W-1:0] ir);
    return ir[DATA_W-OP_W-1 -: REG_AW];
  endfunction

  function automatic logic [REG_AW-1:0] fld_ra(input logic [DATA_W-1:0] ir);
    return ir[DATA_W-OP_W-REG_AW-1 -: REG_AW];
  endfunction

  function automatic logic [REG_AW-1:0] fld_rb(input logic [DATA_W-1:0] ir);
    return ir[DATA_W-OP_W-2*REG_AW-1 -: REG_AW];
  endfunction

  function automatic logic [ADDR_W-1:0] fld_addr(input logic [DATA_W-1:0] ir);
    return ir[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/dp3_regfile.sv
module dp3_regfile
  import dp3_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] ra_a,
  input  logic [REG_AW-1:0] ra_b,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  input  logic              we,
  input  logic [REG_AW-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [REG_AW-1:0] dbg_sel,
  output logic [DATA_W-1:0] dbg_data
);
  logic [DATA_W-1:0] regs [REG_N];

  for (genvar g = 0; g < REG_N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)                                regs[g] <= '0;
      else if (we && (wa == REG_AW'(g)))         regs[g] <= wd;
    end
  end

  assign rd_a     = regs[ra_a];
  assign rd_b     = regs[ra_b];
  assign dbg_data = regs[dbg_sel];
endmodule

// File: rtl/dp3_alu.sv
module dp3_alu
  import dp3_pkg::*;
(
  input  aluop_e            op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_ADD:   y = add_wrap(a, b);
      ALU_PASSA: y = a;
      ALU_PASSB: y = b;
      default:   y = add_wrap(a, DATA_W'(1));
    endcase
  end
endmodule

// File: rtl/dp3_seq.sv
module dp3_seq
  import dp3_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'hFFF,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] ir,
  input  logic              irq_req,
  output ctrl_t             ctrl,
  output logic              boundary,
  output logic              halted,
  output logic              step_done,
  output logic [STEP_W-1:0] step_count
);
  typedef enum logic [3:0] {
    S_F0, S_F1, S_F2, S_EX0, S_EX1, S_EX2, S_I0, S_I1, S_I2, S_STOP
  } state_e;

  state_e            state, state_nx;
  logic              go_stop;
  logic [STEP_W-1:0] cnt;

  always_comb begin
    ctrl       = '0;
    ctrl.rf_ra = fld_ra(ir);
    ctrl.rf_rb = fld_rb(ir);
    ctrl.rf_wa = fld_rd(ir);
    boundary   = 1'b0;
    go_stop    = 1'b0;
    state_nx   = state;
    unique case (state)
      S_F0: begin
        ctrl.a_sel = A_PC; ctrl.op = ALU_PASSA; ctrl.mar_ld = 1'b1;
        state_nx = S_F1;
      end
      S_F1: begin
        ctrl.mem_rd = 1'b1;
        ctrl.a_sel = A_PC; ctrl.op = ALU_INCA; ctrl.pc_ld = 1'b1;
        state_nx = S_F2;
      end
      S_F2: begin
        ctrl.b_sel = B_MEM; ctrl.op = ALU_PASSB;
        ctrl.ir_ld = 1'b1; ctrl.mdr_bus_ld = 1'b1;
        state_nx = S_EX0;
      end
      S_EX0: begin
        unique case (fld_op(ir))
          OPC_RADD: begin
            ctrl.op = ALU_ADD; ctrl.rf_we = 1'b1;
            boundary = 1'b1;
          end
          OPC_MADD: begin
            ctrl.a_sel = A_IRX; ctrl.op = ALU_PASSA; ctrl.mar_ld = 1'b1;
            state_nx = S_EX1;
          end
          OPC_STOP: begin
            boundary = 1'b1; go_stop = 1'b1;
          end
          default: boundary = 1'b1;
        endcase
      end
      S_EX1: begin
        ctrl.mem_rd = 1'b1;
        state_nx = S_EX2;
      end
      S_EX2: begin
        ctrl.rf_ra = '0; ctrl.rf_wa = '0;
        ctrl.a_sel = A_REG; ctrl.b_sel = B_MEM; ctrl.op = ALU_ADD;
        ctrl.rf_we = 1'b1; ctrl.mdr_mem_ld = 1'b1;
        boundary = 1'b1;
      end
      S_I0: begin
        ctrl.a_sel = A_PC; ctrl.op = ALU_PASSA; ctrl.mdr_bus_ld = 1'b1;
        state_nx = S_I1;
      end
      S_I1: begin
        ctrl.a_sel = A_CONST; ctrl.konst = SAVE_ADDR;
        ctrl.op = ALU_PASSA; ctrl.mar_ld = 1'b1;
        state_nx = S_I2;
      end
      S_I2: begin
        ctrl.mem_wr = 1'b1; ctrl.irq_ack = 1'b1;
        ctrl.a_sel = A_CONST; ctrl.konst = HANDLER_ADDR;
        ctrl.op = ALU_PASSA; ctrl.pc_ld = 1'b1;
        boundary = 1'b1;
        state_nx = S_F0;
      end
      default: state_nx = S_STOP;
    endcase
    if (boundary && state != S_I2) begin
      if (go_stop)      state_nx = S_STOP;
      else if (irq_req) state_nx = S_I0;
      else              state_nx = S_F0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_F0;
      cnt        <= '0;
      step_done  <= 1'b0;
      step_count <= '0;
    end else begin
      state     <= state_nx;
      step_done <= boundary;
      if (boundary) begin
        cnt        <= '0;
        step_count <= cnt + 1'b1;
      end else if (state != S_STOP) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign halted = (state == S_STOP);
endmodule

// File: rtl/dp3_core.sv
module dp3_core
  import dp3_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'hFFF,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              irq_req,
  output logic              irq_ack,
  input  logic [REG_AW-1:0] dbg_sel,
  output logic [DATA_W-1:0] dbg_data,
  output logic              halted,
  output logic              step_done,
  output logic [STEP_W-1:0] step_count
);
  ctrl_t             ctrl;
  logic [ADDR_W-1:0] pc_q, mar_q;
  logic [DATA_W-1:0] mdr_q, ir_q;
  logic [DATA_W-1:0] rf_a, rf_b;
  logic [DATA_W-1:0] bus_a, bus_b, in_bus;
  logic              ir_load;
  logic              at_boundary;

  dp3_seq #(.SAVE_ADDR(SAVE_ADDR), .HANDLER_ADDR(HANDLER_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_n), .ir(ir_q), .irq_req(irq_req), .ctrl(ctrl),
    .boundary(at_boundary), .halted(halted),
    .step_done(step_done), .step_count(step_count)
  );

  dp3_regfile u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_a(ctrl.rf_ra), .ra_b(ctrl.rf_rb), .rd_a(rf_a), .rd_b(rf_b),
    .we(ctrl.rf_we), .wa(ctrl.rf_wa), .wd(in_bus),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  always_comb begin
    unique case (ctrl.a_sel)
      A_REG:   bus_a = rf_a;
      A_PC:    bus_a = DATA_W'(pc_q);
      A_IRX:   bus_a = DATA_W'(fld_addr(ir_q));
      default: bus_a = DATA_W'(ctrl.konst);
    endcase
    bus_b = (ctrl.b_sel == B_MEM) ? mem_rdata : rf_b;
  end

  dp3_alu u_alu (.op(ctrl.op), .a(bus_a), .b(bus_b), .y(in_bus));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (ctrl.pc_ld)       pc_q  <= in_bus[ADDR_W-1:0];
      if (ctrl.mar_ld)      mar_q <= in_bus[ADDR_W-1:0];
      if (ctrl.ir_ld)       ir_q  <= in_bus;
      if (ctrl.mdr_mem_ld)  mdr_q <= mem_rdata;
      else if (ctrl.mdr_bus_ld) mdr_q <= in_bus;
    end
  end

  assign ir_load   = ctrl.ir_ld;
  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_rd    = ctrl.mem_rd;
  assign mem_wr    = ctrl.mem_wr;
  assign irq_ack   = ctrl.irq_ack;
endmodule

// File: rtl/dp3_checker.sv
module dp3_checker
  import dp3_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SAVE_ADDR    = 12'hFFF,
  parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic              irq_ack,
  input logic              halted,
  input logic              step_done,
  input logic [STEP_W-1:0] step_count,
  input logic              ir_load,
  input logic              at_boundary
);
  // R11: strobes exclusive
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  // R8: stop is sticky and quiet
  a_r8_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_rd && !mem_wr && !irq_ack));

  // R7: acknowledge coincides with the save write at the fixed address
  a_r7_ack_saves: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> (mem_wr && mem_addr == SAVE_ADDR));

  // R7: acknowledge only at a completion point
  a_r7_ack_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> at_boundary);

  // R7: handler fetch two cycles after entry ends
  a_r7_vector_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> ##2 (mem_rd && mem_addr == HANDLER_ADDR));

  // R6: instruction word taken the cycle after the read strobe
  a_r6_ir_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |-> $past(mem_rd));

  // R3 R5 R7 R8 R9: only legal cycle counts are reported
  a_r3_step_legal: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |-> (step_count == 4'd3 || step_count == 4'd4 || step_count == 4'd6));

  // R2: a new fetch begins after each completion, strobing two cycles later
  a_r2_fetch_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    (at_boundary && !irq_ack && !$past(halted) && $fell(at_boundary) == 1'b0
     && !halted) |=> (halted || !mem_rd));
endmodule

bind dp3_core dp3_checker #(.SAVE_ADDR(SAVE_ADDR), .HANDLER_ADDR(HANDLER_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .irq_ack(irq_ack), .halted(halted), .step_done(step_done), .step_count(step_count),
  .ir_load(ir_load), .at_boundary(at_boundary)
);

// File: tb/tb_dp3_core.sv
module tb_dp3_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        irq_req = 1'b0;
  logic        irq_ack;
  logic [1:0]  dbg_sel = 2'd0;
  logic [15:0] dbg_data;
  logic        halted, step_done;
  logic [3:0]  step_count;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [15:0] mem [0:4095];
  logic [15:0] rd_q;
  logic        rd_valid;

  int got_steps[$];
  int got_reads[$];
  int exp_steps[$];
  int exp_reads[$];
  logic [15:0] model_r [4];

  dp3_core dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq_req(irq_req), .irq_ack(irq_ack),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data), .halted(halted),
    .step_done(step_done), .step_count(step_count)
  );

  always #10 clk = ~clk;

  // memory: data only in the cycle after a strobe, poison otherwise
  always @(posedge clk) begin
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    rd_valid <= mem_rd;
    rd_q     <= mem[mem_addr];
  end
  assign mem_rdata = rd_valid ? rd_q : 16'hBAD0;

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (rst_n) begin
      if (step_done) got_steps.push_back(int'(step_count));
      if (mem_rd)    got_reads.push_back(int'(mem_addr));
    end
  end

  always @(posedge clk) begin
    if (cycles > 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] sum16(input logic [15:0] a, input logic [15:0] b);
    int s;
    s = (int'(a) + int'(b)) % 65536;
    return s[15:0];
  endfunction

  function automatic logic [15:0] op_radd(input int rd, input int ra, input int rb);
    return 16'h1000 | 16'(rd << 10) | 16'(ra << 8) | 16'(rb << 6);
  endfunction

  function automatic logic [15:0] op_madd(input int x);
    return 16'h2000 | 16'(x & 12'hFFF);
  endfunction

  task automatic clear_all();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
    for (int i = 0; i < 4; i++) model_r[i] = 16'h0;
    exp_steps.delete(); exp_reads.delete();
  endtask

  task automatic do_reset(input string tag);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    got_steps.delete(); got_reads.delete();
    rst_n = 1'b1;
    #1;
    chk(halted == 1'b0, "R1 halted", halted, 0);
    chk(!mem_rd && !mem_wr && !irq_ack && !step_done, "R1 strobes idle",
        {mem_rd, mem_wr, irq_ack, step_done}, 0);
    for (int i = 0; i < 4; i++) begin
      dbg_sel = 2'(i);
      #1;
      chk(dbg_data == 16'h0, {"R1 reg clear ", tag}, dbg_data, 0);
    end
  endtask

  task automatic run_to_halt(input string tag);
    int n;
    n = 0;
    while (!halted && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(halted == 1'b1, {"R8 reached halt ", tag}, halted, 1);
    repeat (2) @(negedge clk);
  endtask

  task automatic compare_all(input string tag);
    chk(got_steps.size() == exp_steps.size(), {"R3 R5 R9 step list length ", tag},
        got_steps.size(), exp_steps.size());
    for (int i = 0; i < exp_steps.size() && i < got_steps.size(); i++)
      if (got_steps[i] != exp_steps[i])
        chk(1'b0, {"R3 R5 R7 R9 step count ", tag}, got_steps[i], exp_steps[i]);
    chk(got_reads.size() == exp_reads.size(), {"R2 R5 read list length ", tag},
        got_reads.size(), exp_reads.size());
    for (int i = 0; i < exp_reads.size() && i < got_reads.size(); i++)
      if (got_reads[i] != exp_reads[i])
        chk(1'b0, {"R2 R5 read address ", tag}, got_reads[i], exp_reads[i]);
    for (int i = 0; i < 4; i++) begin
      dbg_sel = 2'(i);
      #1;
      chk(dbg_data == model_r[i], {"R10 R12 register value ", tag}, dbg_data, model_r[i]);
    end
  endtask

  // program builders keep the bench model in step
  task automatic put_radd(inout int pc, input int rd, input int ra, input int rb);
    mem[pc] = op_radd(rd, ra, rb);
    exp_reads.push_back(pc); exp_steps.push_back(4);
    model_r[rd] = sum16(model_r[ra], model_r[rb]);
    pc++;
  endtask

  task automatic put_madd(inout int pc, input int x, input logic [15:0] v);
    mem[pc] = op_madd(x);
    mem[x]  = v;
    exp_reads.push_back(pc); exp_reads.push_back(x); exp_steps.push_back(6);
    model_r[0] = sum16(model_r[0], v);
    pc++;
  endtask

  task automatic put_nop(inout int pc, input logic [3:0] opc);
    mem[pc] = {opc, 12'hFFF};
    exp_reads.push_back(pc); exp_steps.push_back(4);
    pc++;
  endtask

  task automatic put_stop(inout int pc);
    mem[pc] = 16'hF000;
    exp_reads.push_back(pc); exp_steps.push_back(4);
    pc++;
  endtask

  initial begin
    int pc;
    void'($urandom(32'd1357));
    clear_all();
    do_reset("first");

    // directed: load, self-doubling (R4), wrap (R12), no-op (R9), stop
    pc = 0;
    put_madd(pc, 12'h200, 16'h1234);
    put_radd(pc, 1, 0, 0);
    put_radd(pc, 1, 1, 1);          // R4: destination is both sources
    put_madd(pc, 12'h201, 16'hFFFF); // R12: wraps R0
    put_nop(pc, 4'h7);               // R9
    put_radd(pc, 2, 0, 1);
    put_stop(pc);
    run_to_halt("directed");
    compare_all("directed");
    chk(model_r[1] == 16'h48D0, "R4 doubled twice in model", model_r[1], 16'h48D0);

    // stop ignores interrupt; no strobes afterwards (R8)
    begin
      int acks, strobes;
      acks = 0; strobes = 0;
      irq_req = 1'b1;
      repeat (20) begin
        @(negedge clk);
        if (irq_ack) acks++;
        if (mem_rd || mem_wr) strobes++;
      end
      irq_req = 1'b0;
      chk(acks == 0, "R8 interrupt ignored after stop", acks, 0);
      chk(strobes == 0, "R8 no strobes after stop", strobes, 0);
      chk(halted == 1'b1, "R8 halted sticky", halted, 1);
    end

    // interrupt raised mid memory-add, handled at the boundary (R7)
    clear_all();
    do_reset("irq");
    pc = 0;
    put_madd(pc, 12'h210, 16'h0005);
    mem[1] = op_radd(1, 0, 0);        // must not run before the handler
    exp_steps.push_back(3);
    pc = 12'h100;
    put_radd(pc, 2, 0, 0);
    put_stop(pc);
    fork
      begin
        int n;
        n = 0;
        while (!(mem_rd && mem_addr == 12'h210) && n < 200) begin @(negedge clk); n++; end
        irq_req = 1'b1;
        n = 0;
        while (!irq_ack && n < 200) begin @(negedge clk); n++; end
        chk(irq_ack == 1'b1, "R7 acknowledge seen", irq_ack, 1);
        chk(mem_wr && mem_addr == 12'hFFF && mem_wdata == 16'h0001,
            "R7 save write of return address", mem_wdata, 16'h0001);
        irq_req = 1'b0;
      end
      run_to_halt("irq");
    join
    compare_all("irq");
    chk(mem[12'hFFF] == 16'h0001, "R7 saved word in memory", mem[12'hFFF], 16'h0001);

    // random programs
    for (int round = 0; round < 4; round++) begin
      clear_all();
      do_reset("random");
      pc = 0;
      for (int k = 0; k < 40; k++) begin
        int kind;
        kind = int'($urandom % 4);
        if (kind == 0 || kind == 3)
          put_radd(pc, int'($urandom % 4), int'($urandom % 4), int'($urandom % 4));
        else if (kind == 1)
          put_madd(pc, 12'h400 + k, 16'($urandom));
        else begin
          logic [3:0] o;
          o = 4'(3 + ($urandom % 12));
          if (o == 4'hF) o = 4'h0;
          put_nop(pc, o);
        end
      end
      put_stop(pc);
      run_to_halt("random");
      compare_all("random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule